// File: doc/BRIEF.md
# SD Card Clock Divider and Gate

This block derives the card clock of an SD host from the host's base clock. Software controls it through one 16-bit control word. The word holds an internal-clock enable, a read-only stability flag, a card-clock enable and a 10-bit frequency-select code. A static mode input chooses how the code is read. In legacy mode only the low 8 bits count, and they form a power-of-two code. In linear mode all 10 bits count, and a code N divides by 2N.

The block runs on `clk`, which runs at twice the base-clock frequency. A divide ratio D therefore shows up on `sd_clk` as D `clk` cycles high followed by D cycles low, so every ratio, including 1 (pass-through), keeps a 50% duty cycle. The bring-up order is: enable the internal clock with a divider code, poll the stability flag until it reads 1, then set the card-clock enable. Before a new code is written, the card-clock enable is cleared. The block delays the output until the clock is stable even when software skips the poll. It never shortens a phase of `sd_clk` when the output is started or stopped.

Top module: `sd_clock_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0000h and `sd_clk` is low.
- R2: Control word layout: bit 0 is the internal-clock enable, bit 1 is the stability flag (read-only; writes to it are ignored), bit 2 is the card-clock enable, bits [5:3] read 0, bits [15:8] hold select bits [7:0] and bits [7:6] hold select bits [9:8]. All writable fields read back as written.
- R3: In legacy mode (`legacy_mode`=1), a select low byte of 00h gives ratio 1. A low byte with only bit k set gives ratio 2^(k+1), so 80h gives 256.
- R4: In legacy mode, a low byte with more than one bit set acts as if only its highest set bit were set.
- R5: In legacy mode, select bits [9:8] (word bits [7:6]) do not affect the ratio. Rewriting only them leaves the stability flag set and leaves the `sd_clk` phase lengths unchanged.
- R6: In linear mode (`legacy_mode`=0), a 10-bit select N from 1 to 3FFh gives ratio 2N, with 3FFh giving 2046. N=0 gives ratio 1.
- R7: The stability flag reads 0 right after the clock edge that writes internal-clock enable 0 or changes the effective ratio. It reads 1 exactly STABLE_CYCLES edges later, provided no further such write occurs.
- R8: `sd_clk` stays low while the card-clock enable is 0 or the stability flag is 0, including when both enables are written in the same cycle.
- R9: With ratio D running and gated on, every `sd_clk` high phase and every low phase lasts exactly D `clk` cycles. Clearing the card-clock enable during a high phase lets that phase finish at full length, and the output then stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the base-clock frequency |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode | input | 1 | Static select: 1 = power-of-two code, 0 = linear 10-bit code |
| wr_en | input | 1 | Writes `wr_data` into the control word at the clock edge |
| wr_data | input | 16 | Control word write value |
| rd_data | output | 16 | Current control word, including the stability flag |
| sd_clk | output | 1 | Gated, divided card clock |

## Verification
On every cycle, the assertions check that the card clock never rises unless both the enable and the stability flag were already set (R8). They also check that a falling output edge coincides with the divided clock being low (R9), that clearing the internal enable drops the stability flag and the output (R7), and that the active ratio stays a power of two in legacy mode (R4) or an even value up to 2046 in linear mode (R6). Only the bench scenarios can show the exact phase lengths for each code, the choice of the highest set bit, the exact stability delay and the fact that bits [7:6] are ignored in legacy mode. These are compared against ratios the bench computes itself.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    localparam int SEL_W  = 10;
    localparam int LO_W   = 8;
    localparam int HALF_W = 12;
    localparam int WORD_W = 16;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [SEL_W-1:0]  sel_t;

    typedef struct packed {
        sel_t sel;
        logic sd_en;
        logic ice;
    } ctrl_t;

    // Half period in clk cycles (equals the divide ratio of the base clock)
    function automatic half_t decode_half(input sel_t sel, input logic legacy);
        half_t h;
        h = half_t'(1);
        if (legacy) begin
            for (int i = 0; i < LO_W; i++) begin
                if (sel[i]) h = half_t'(1) << (i + 1);
            end
        end else if (sel != '0) begin
            h = half_t'({sel, 1'b0});
        end
        return h;
    endfunction

    function automatic ctrl_t unpack_word(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.sel   = {w[7:6], w[15:8]};
        c.sd_en = w[2];
        c.ice   = w[0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input ctrl_t c, input logic stable);
        return {c.sel[7:0], c.sel[9:8], 3'b000, c.sd_en, stable, c.ice};
    endfunction

endpackage

// File: rtl/sdclk_ctrl_reg.sv
module sdclk_ctrl_reg
    import sdclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              legacy_mode,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output ctrl_t             ctrl_o,
    output half_t             half_o,
    output logic              restart_o
);

    ctrl_t ctrl_q, ctrl_n;
    half_t half_q, half_n;

    always_comb begin
        ctrl_n    = wr_en ? unpack_word(wr_data) : ctrl_q;
        half_n    = decode_half(ctrl_n.sel, legacy_mode);
        restart_o = (half_n != half_q) || !ctrl_n.ice;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            half_q <= half_t'(1);
        end else begin
            ctrl_q <= ctrl_n;
            half_q <= half_n;
        end
    end

    assign ctrl_o = ctrl_q;
    assign half_o = half_q;

    // R4: legacy ratio is always a single power of two
    a_r4_legacy_pow2: assert property (@(posedge clk) disable iff (rst)
        (legacy_mode && $stable(legacy_mode)) |-> ($countones(half_q) == 1));

    // R6: linear ratio is 1 or an even value not above 2046
    a_r6_linear_range: assert property (@(posedge clk) disable iff (rst)
        (!legacy_mode && $stable(legacy_mode)) |->
            ((half_q == half_t'(1)) || (!half_q[0] && half_q <= half_t'(2046))));

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
    import sdclk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ice,
    input  logic  restart,
    input  half_t half,
    output logic  div_q_o,
    output logic  div_n_o
);

    half_t cnt_q, cnt_n;
    logic  div_q, div_n;

    always_comb begin
        cnt_n = cnt_q;
        div_n = div_q;
        if (restart || !ice) begin
            cnt_n = '0;
            div_n = 1'b0;
        end else if (cnt_q == half - half_t'(1)) begin
            cnt_n = '0;
            div_n = ~div_q;
        end else begin
            cnt_n = cnt_q + half_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            div_q <= 1'b0;
        end else begin
            cnt_q <= cnt_n;
            div_q <= div_n;
        end
    end

    assign div_q_o = div_q;
    assign div_n_o = rst ? 1'b0 : div_n;

endmodule

// File: rtl/sdclk_gate.sv
module sdclk_gate #(
    parameter int STABLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic ice,
    input  logic restart,
    input  logic sd_en,
    input  logic div_q,
    input  logic div_n,
    output logic stable_o,
    output logic sdclk_o
);

    localparam int CW = $clog2(STABLE_CYCLES + 1);

    logic [CW-1:0] scnt_q;
    logic          stable_q;
    logic          gate_q, gate_n;
    logic          sdclk_q;

    always_ff @(posedge clk) begin
        if (rst || restart || !ice) begin
            scnt_q   <= '0;
            stable_q <= 1'b0;
        end else if (!stable_q) begin
            if (scnt_q == CW'(STABLE_CYCLES - 1)) stable_q <= 1'b1;
            else                                   scnt_q   <= scnt_q + CW'(1);
        end
    end

    // Gate only moves while the divided clock is low
    always_comb begin
        if (restart || !ice)  gate_n = 1'b0;
        else if (!div_q)      gate_n = sd_en && stable_q;
        else                  gate_n = gate_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q  <= 1'b0;
            sdclk_q <= 1'b0;
        end else begin
            gate_q  <= gate_n;
            sdclk_q <= div_n && gate_n;
        end
    end

    assign stable_o = stable_q;
    assign sdclk_o  = sdclk_q;

    // R8: no rising card clock unless enabled and stable beforehand
    a_r8_gated_rise: assert property (@(posedge clk) disable iff (rst)
        !(sd_en && stable_q) |=> !$rose(sdclk_q));

    // R9: a falling output edge only where the divided clock is low
    a_r9_no_runt: assert property (@(posedge clk) disable iff (rst)
        $fell(sdclk_q) |-> !div_q);

endmodule

// File: rtl/sd_clock_ctrl.sv
module sd_clock_ctrl
    import sdclk_pkg::*;
#(
    parameter int STABLE_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        legacy_mode,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic        sd_clk
);

    ctrl_t ctrl;
    half_t half;
    logic  restart, div_q, div_n, stable;

    sdclk_ctrl_reg u_reg (
        .clk         (clk),
        .rst         (rst),
        .legacy_mode (legacy_mode),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .ctrl_o      (ctrl),
        .half_o      (half),
        .restart_o   (restart)
    );

    sdclk_divider u_div (
        .clk     (clk),
        .rst     (rst),
        .ice     (ctrl.ice),
        .restart (restart),
        .half    (half),
        .div_q_o (div_q),
        .div_n_o (div_n)
    );

    sdclk_gate #(.STABLE_CYCLES(STABLE_CYCLES)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .ice      (ctrl.ice),
        .restart  (restart),
        .sd_en    (ctrl.sd_en),
        .div_q    (div_q),
        .div_n    (div_n),
        .stable_o (stable),
        .sdclk_o  (sd_clk)
    );

    assign rd_data = pack_word(ctrl, stable);

    // R7: writing the internal enable low drops the flag and the output
    a_r7_ice_off: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[0]) |=> (!rd_data[1] && !sd_clk));

endmodule

// File: tb/sd_clock_ctrl_test.sv
module sd_clock_ctrl_test;

    localparam int STABLE = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        legacy_mode = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        sd_clk;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    sd_clock_ctrl #(.STABLE_CYCLES(STABLE)) uut (
        .clk(clk), .rst(rst), .legacy_mode(legacy_mode),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .sd_clk(sd_clk)
    );

    function automatic int exp_ratio(input int sel, input bit legacy);
        if (legacy) begin
            for (int b = 7; b >= 0; b--)
                if (((sel >> b) & 1) != 0) return 2 << b;
            return 1;
        end
        if ((sel & 10'h3FF) == 0) return 1;
        return 2 * (sel & 10'h3FF);
    endfunction

    function automatic logic [15:0] mk(input int sel, input bit sd_en, input bit ice);
        logic [9:0] s;
        s = sel[9:0];
        return {s[7:0], s[9:8], 3'b000, sd_en, 1'b0, ice};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset(input bit legacy);
        rst = 1'b1;
        legacy_mode = legacy;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_stable();
        for (int i = 0; i < STABLE + 8; i++) begin
            if (rd_data[1]) return;
            @(negedge clk);
        end
    endtask

    task automatic measure(input int d, input string req);
        int  hi, lo, guard;
        logic prev;
        prev = sd_clk;
        guard = 0;
        forever begin
            @(negedge clk);
            if (!prev && sd_clk) break;
            prev = sd_clk;
            guard++;
            if (guard > 3 * d + 64) begin
                check(1'b0, req, 0, d);
                return;
            end
        end
        hi = 1;
        while (hi < 3 * d + 8) begin
            @(negedge clk);
            if (!sd_clk) break;
            hi++;
        end
        lo = 1;
        while (lo < 3 * d + 8) begin
            @(negedge clk);
            if (sd_clk) break;
            lo++;
        end
        check(hi == d, {req, " high phase"}, hi, d);
        check(lo == d, {req, " low phase"}, lo, d);
    endtask

    task automatic run_code(input int sel, input bit legacy, input string req);
        wr({rd_data[15:3], 1'b0, rd_data[1:0]});
        wr(mk(sel, 1'b0, 1'b1));
        wait_stable();
        wr(mk(sel, 1'b1, 1'b1));
        measure(exp_ratio(sel, legacy), req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int r;
        int low_run;
        r = $urandom(32'd7051);

        // R1: reset state
        do_reset(1'b1);
        check(rd_data == 16'h0000, "R1 rd_data", int'(rd_data), 0);
        check(sd_clk == 1'b0, "R1 sd_clk", int'(sd_clk), 0);

        // R7: exact stability timing after enabling
        wr(mk(0, 1'b0, 1'b1));
        check(rd_data[1] == 1'b0, "R7 flag low after write", int'(rd_data[1]), 0);
        repeat (STABLE - 1) @(negedge clk);
        check(rd_data[1] == 1'b0, "R7 flag low one edge early", int'(rd_data[1]), 0);
        @(negedge clk);
        check(rd_data[1] == 1'b1, "R7 flag set on time", int'(rd_data[1]), 1);

        // R8: stable but card clock disabled -> stays low
        low_run = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!sd_clk) low_run++;
        end
        check(low_run == 20, "R8 low while disabled", low_run, 20);

        // R3: legacy pass-through and one-hot codes
        run_code(10'h000, 1'b1, "R3 code 00h");
        run_code(10'h080, 1'b1, "R3 code 80h");
        run_code(10'h008, 1'b1, "R3 code 08h");

        // R4: multi-bit codes use the highest set bit
        run_code(10'h005, 1'b1, "R4 code 05h");
        run_code(10'h0FF, 1'b1, "R4 code FFh");
        for (int k = 0; k < 4; k++) run_code(int'($urandom % 256), 1'b1, "R4 random code");

        // R5: bits [7:6] ignored in legacy mode
        run_code(10'h004, 1'b1, "R5 baseline");
        wr(mk(10'h304, 1'b1, 1'b1));
        check(rd_data[1] == 1'b1, "R5 flag kept", int'(rd_data[1]), 1);
        check(rd_data[7:6] == 2'b11, "R2 bits 7:6 stored", int'(rd_data[7:6]), 3);
        measure(8, "R5 ratio unchanged");

        // R7: internal enable cleared
        wr(mk(10'h004, 1'b1, 1'b0));
        check(rd_data[1] == 1'b0, "R7 flag cleared by enable off", int'(rd_data[1]), 0);
        low_run = 0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (!sd_clk) low_run++;
        end
        check(low_run == 24, "R7 output off with enable off", low_run, 24);

        // Linear mode
        do_reset(1'b0);

        // R2: layout readback
        wr(16'hA586 | 16'h0007);
        check(rd_data == 16'hA585, "R2 readback", int'(rd_data), 16'hA585);

        // R8: both enables written together -> low until stable
        wr(mk(10'h003, 1'b1, 1'b1));
        low_run = 0;
        for (int i = 0; i < STABLE + 8; i++) begin
            if (rd_data[1]) break;
            if (sd_clk) low_run++;
            @(negedge clk);
        end
        check(low_run == 0, "R8 no pulse before stable", low_run, 0);
        measure(6, "R8 runs after stable");

        // R6: linear codes
        run_code(10'h000, 1'b0, "R6 code 0");
        run_code(10'h001, 1'b0, "R6 code 1");
        run_code(10'h100, 1'b0, "R6 code 100h");
        run_code(10'h3FF, 1'b0, "R6 code 3FFh");
        for (int k = 0; k < 3; k++) run_code(int'($urandom % 1024), 1'b0, "R6 random code");

        // R9: stop during a high phase keeps it full length
        run_code(10'h004, 1'b0, "R9 setup");
        begin
            int hi;
            logic prev;
            prev = sd_clk;
            for (int i = 0; i < 64; i++) begin
                @(negedge clk);
                if (!prev && sd_clk) break;
                prev = sd_clk;
            end
            hi = 1;
            wr_en = 1'b1;
            wr_data = mk(10'h004, 1'b0, 1'b1);
            @(negedge clk);
            wr_en = 1'b0;
            if (sd_clk) hi++;
            while (hi < 40) begin
                @(negedge clk);
                if (!sd_clk) break;
                hi++;
            end
            check(hi == 8, "R9 last high phase full", hi, 8);
        end
        low_run = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!sd_clk) low_run++;
        end
        check(low_run == 40, "R9 stays low after stop", low_run, 40);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule